// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Data Unit

This block is the arithmetic core of a 24-bit fixed-point signal processor. It holds four 24-bit operand registers and two 56-bit accumulators. Each accumulator has an 8-bit extension byte above a 48-bit value, and the 48-bit value splits into an upper word and a lower word. An operation is issued by raising `op_valid` with a 4-bit code, two operand-register selects and a destination accumulator select. Every operation takes one clock and writes its result into the destination accumulator at that clock edge. There is no pipelining. The accumulator that is not the destination is called the partner.

Operands are two's-complement fractions. A product is formed from two operand registers. It is sign-extended to 56 bits and shifted left one place, so the redundant sign bit drops out and the binary point lines up with the accumulator's upper word. Multiply-accumulate can add the product to the destination or subtract it, and either form can be followed by round-half-to-even rounding at the word boundary. Add, subtract, one-bit shifts and bitwise logic on the upper word complete the operation set.

Values enter through a load port that writes 24-bit or 48-bit words. Accumulators are read through a limiter. When the extension byte holds significant bits, the limiter returns the largest positive or negative value of the requested width and sets a sticky limit flag. An unlimited 56-bit view of the selected accumulator is also presented.

Top module: `fmac_unit`

## Requirements
- R1: After a clock with `rst_n` low, all four operand registers and both accumulators are zero and `lim_flag` is 0.
- R2: `ld_tgt` values 0..3 select an operand register, which takes `ld_data[23:0]`. Value 4 selects accumulator 0 and value 5 selects accumulator 1. With `ld_wide`=0 the accumulator's upper word takes `ld_data[23:0]`, its lower word is cleared and the extension copies bit 23. With `ld_wide`=1 it takes `ld_data[47:0]`, sign-extended through the extension.
- R3: Code 1 (multiply) writes the signed product of operand registers `src_a` and `src_b`, sign-extended to 56 bits and shifted left one place. -1.0 times -1.0 gives 0x00_800000_000000.
- R4: Codes 3 and 4 write the destination plus the product and the destination minus the product, with 56-bit wraparound.
- R5: Codes 2, 5, 6 and 10 round: the product, destination+product, destination−product and the destination alone. Rounding adds 0x800000, clears the lower 24 bits, and on an exact tie (lower word 0x800000 before rounding) clears bit 24 so the upper word is even.
- R6: Code 7 adds the partner accumulator to the destination. Code 8 subtracts the partner from the destination. Code 9 adds operand register `src_a`, placed in the upper word and sign-extended, to the destination.
- R7: Code 11 shifts the whole 56-bit destination left one bit. Code 12 shifts it right one bit and keeps the sign.
- R8: Codes 13, 14 and 15 apply AND, OR and XOR of operand register `src_a` to the destination's upper word and leave its extension and lower word unchanged.
- R9: Code 0 and a low `op_valid` change no accumulator. An operation never changes the partner accumulator.
- R10: `rd_full` shows accumulator `rd_sel`. The value counts as overflowed when its extension bits [55:48] are not all equal to bit 47. If it has not overflowed, `rd_data` is `rd_full[47:24]` for a 24-bit read (`rd_wide`=0, upper bits zero) or `rd_full[47:0]` for a 48-bit read. If it has overflowed, a positive value reads 0x7FFFFF or 0x7FFFFF_FFFFFF and a negative value reads 0x800000 or 0x800000_000000.
- R11: `lim_flag` rises after a clock with `rd_en` high on an overflowed value. It stays high until a clock with `lim_clr` high. If a set and a clear fall in the same clock, the set wins.
- R12: An operation always reads operand and accumulator values from before the current clock edge, so a load in the same cycle takes effect only for later operations. If a load and an operation target the same accumulator in the same cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_code | input | 4 | Operation code |
| src_a | input | 2 | First operand register select |
| src_b | input | 2 | Second operand register select |
| acc_dst | input | 1 | Destination accumulator; the other one is the partner |
| ld_en | input | 1 | Load strobe |
| ld_tgt | input | 3 | Load target: 0..3 operand registers, 4 and 5 accumulators |
| ld_wide | input | 1 | 1 = 48-bit accumulator load, 0 = 24-bit |
| ld_data | input | 48 | Load data |
| rd_en | input | 1 | Read strobe; arms the limit flag |
| rd_sel | input | 1 | Accumulator to read |
| rd_wide | input | 1 | 1 = 48-bit read, 0 = 24-bit read |
| lim_clr | input | 1 | Clear the limit flag |
| rd_data | output | 48 | Limited read data |
| rd_full | output | 56 | Unlimited selected accumulator |
| lim_flag | output | 1 | Sticky limit flag |

## Verification
Two pairs of functions can act in the same cycle, and both are driven on purpose. The first pair is a load and an operation. An operand register is reloaded in the same cycle as a multiply that reads it: the result must use the old value, and the next multiply must use the new one. An accumulator load is also issued in the same cycle as an operation aimed at that accumulator: the loaded value must remain. The second pair is a set and a clear of the limit flag. An overflowed read is issued together with `lim_clr`, and the flag must stay high.

// File: rtl/fmac_pkg.sv
// Package: operation codes and load-target helpers shared by the data unit.
// Assumes a 4-bit operation code field.
package fmac_pkg;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_NOP    = 4'd0,
        OP_MUL    = 4'd1,
        OP_MULR   = 4'd2,
        OP_MACP   = 4'd3,
        OP_MACM   = 4'd4,
        OP_MACPR  = 4'd5,
        OP_MACMR  = 4'd6,
        OP_ADDACC = 4'd7,
        OP_SUBACC = 4'd8,
        OP_ADDIN  = 4'd9,
        OP_ROUND  = 4'd10,
        OP_SHL    = 4'd11,
        OP_SHR    = 4'd12,
        OP_AND    = 4'd13,
        OP_OR     = 4'd14,
        OP_XOR    = 4'd15
    } op_e;

    // True for the operations that touch only the upper word
    function automatic logic is_logic_op(input op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction
endpackage

// File: rtl/fmac_mult.sv
// Fractional multiplier: signed DW x DW product, sign-extended to the
// accumulator width and shifted left once to drop the duplicate sign bit.
// Assumes operands are two's-complement fractions.
module fmac_mult #(
    parameter int DW = 24,
    parameter int EW = 8,
    localparam int AW = 2*DW + EW
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [AW-1:0] prod
);
    logic signed [2*DW-1:0] raw;

    // Form the product and align the binary point with the upper word
    always_comb begin
        raw  = $signed(a) * $signed(b);
        prod = {{EW{raw[2*DW-1]}}, raw} << 1;
    end
endmodule

// File: rtl/fmac_round.sv
// Convergent (round half to even) rounder at the DW-bit word boundary.
// Assumes the input is an accumulator-width two's-complement value; the
// result wraps modulo 2**AW.
module fmac_round #(
    parameter int DW = 24,
    parameter int EW = 8,
    localparam int AW = 2*DW + EW
) (
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);
    localparam logic [AW-1:0] HALF    = AW'(1) << (DW-1);
    localparam logic [AW-1:0] LOWMASK = (AW'(1) << DW) - AW'(1);
    localparam logic [AW-1:0] LSBMASK = AW'(1) << DW;

    logic          tie;
    logic [AW-1:0] sum;

    // Add half an upper-word LSB, drop the lower word, force even on a tie
    always_comb begin
        tie  = (din[DW-1:0] == HALF[DW-1:0]);
        sum  = din + HALF;
        dout = sum & ~LOWMASK & ~(tie ? LSBMASK : '0);
    end
endmodule

// File: rtl/fmac_datapath.sv
// Combinational operation datapath: computes the next destination value
// from the selected operands and accumulators. Assumes the caller
// registers the result and decides write priority.
module fmac_datapath
    import fmac_pkg::*;
#(
    parameter int DW = 24,
    parameter int EW = 8,
    localparam int AW = 2*DW + EW
) (
    input  op_e           op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [AW-1:0] acc_d,
    input  logic [AW-1:0] acc_o,
    output logic [AW-1:0] res,
    output logic          wr
);
    logic [AW-1:0] prod;
    logic [AW-1:0] pre;
    logic [AW-1:0] rnd;
    logic [AW-1:0] in_word;
    logic [DW-1:0] hi;
    logic [DW-1:0] hi_new;
    logic          do_rnd;

    fmac_mult #(.DW(DW), .EW(EW)) u_mult (.a(opa), .b(opb), .prod(prod));
    fmac_round #(.DW(DW), .EW(EW)) u_round (.din(pre), .dout(rnd));

    // Upper-word view of the destination and the logic-op result
    always_comb begin
        hi      = acc_d[2*DW-1:DW];
        in_word = {{EW{opa[DW-1]}}, opa, {DW{1'b0}}};
        unique case (op)
            OP_AND:  hi_new = hi & opa;
            OP_OR:   hi_new = hi | opa;
            default: hi_new = hi ^ opa;
        endcase
    end

    // Select the pre-rounding value for each operation code
    always_comb begin
        pre    = acc_d;
        do_rnd = 1'b0;
        wr     = 1'b1;
        unique case (op)
            OP_NOP:    wr = 1'b0;
            OP_MUL:    pre = prod;
            OP_MULR:   begin pre = prod;         do_rnd = 1'b1; end
            OP_MACP:   pre = acc_d + prod;
            OP_MACM:   pre = acc_d - prod;
            OP_MACPR:  begin pre = acc_d + prod; do_rnd = 1'b1; end
            OP_MACMR:  begin pre = acc_d - prod; do_rnd = 1'b1; end
            OP_ADDACC: pre = acc_d + acc_o;
            OP_SUBACC: pre = acc_d - acc_o;
            OP_ADDIN:  pre = acc_d + in_word;
            OP_ROUND:  do_rnd = 1'b1;
            OP_SHL:    pre = acc_d << 1;
            OP_SHR:    pre = AW'($signed(acc_d) >>> 1);
            default:   pre = {acc_d[AW-1:2*DW], hi_new, acc_d[DW-1:0]};
        endcase
    end

    // Final result: rounded or direct
    always_comb res = do_rnd ? rnd : pre;
endmodule

// File: rtl/fmac_limiter.sv
// Read-out limiter: passes the upper word or the full 48-bit value, or
// substitutes the extreme value of that width when the extension byte
// carries significant bits. Assumes a two's-complement accumulator.
module fmac_limiter #(
    parameter int DW = 24,
    parameter int EW = 8,
    localparam int AW = 2*DW + EW,
    localparam int RW = 2*DW
) (
    input  logic [AW-1:0] acc,
    input  logic          wide,
    output logic [RW-1:0] data,
    output logic          ovf
);
    localparam logic [RW-1:0] POS_W = {1'b0, {RW-1{1'b1}}};
    localparam logic [RW-1:0] NEG_W = {1'b1, {RW-1{1'b0}}};
    localparam logic [DW-1:0] POS_N = {1'b0, {DW-1{1'b1}}};
    localparam logic [DW-1:0] NEG_N = {1'b1, {DW-1{1'b0}}};

    logic neg;

    // Detect significant extension bits and choose the limited value
    always_comb begin
        ovf = (acc[AW-1:RW] != {EW{acc[RW-1]}});
        neg = acc[AW-1];
        if (wide)
            data = ovf ? (neg ? NEG_W : POS_W) : acc[RW-1:0];
        else
            data = {{DW{1'b0}}, (ovf ? (neg ? NEG_N : POS_N) : acc[RW-1:DW])};
    end
endmodule

// File: rtl/fmac_unit.sv
// Fractional multiply-accumulate data unit (top). Holds NIN operand
// registers and two accumulators, applies one operation per clock, and
// provides a load port and a limited read port with a sticky limit flag.
// Assumes synchronous active-low reset; loads win over operation writes.
module fmac_unit
    import fmac_pkg::*;
#(
    parameter int DW  = 24,
    parameter int EW  = 8,
    parameter int NIN = 4,
    localparam int AW   = 2*DW + EW,
    localparam int RW   = 2*DW,
    localparam int SELW = $clog2(NIN),
    localparam int TGW  = $clog2(NIN + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [OPW-1:0]  op_code,
    input  logic [SELW-1:0] src_a,
    input  logic [SELW-1:0] src_b,
    input  logic            acc_dst,
    input  logic            ld_en,
    input  logic [TGW-1:0]  ld_tgt,
    input  logic            ld_wide,
    input  logic [RW-1:0]   ld_data,
    input  logic            rd_en,
    input  logic            rd_sel,
    input  logic            rd_wide,
    input  logic            lim_clr,
    output logic [RW-1:0]   rd_data,
    output logic [AW-1:0]   rd_full,
    output logic            lim_flag
);
    logic [DW-1:0] in_q  [NIN];
    logic [AW-1:0] acc_q [2];
    logic [DW-1:0] opa;
    logic [DW-1:0] opb;
    logic [AW-1:0] acc_d;
    logic [AW-1:0] acc_o;
    logic [AW-1:0] res;
    logic          wr;
    logic [AW-1:0] ld_acc_val;
    logic          rd_ovf;

    // Operand and accumulator selection for the current operation
    always_comb begin
        opa   = in_q[src_a];
        opb   = in_q[src_b];
        acc_d = acc_q[acc_dst];
        acc_o = acc_q[~acc_dst];
    end

    // Accumulator load value: narrow fills the upper word, wide fills both
    always_comb begin
        if (ld_wide)
            ld_acc_val = {{EW{ld_data[RW-1]}}, ld_data};
        else
            ld_acc_val = {{EW{ld_data[DW-1]}}, ld_data[DW-1:0], {DW{1'b0}}};
    end

    fmac_datapath #(.DW(DW), .EW(EW)) u_dp (
        .op(op_e'(op_code)), .opa(opa), .opb(opb),
        .acc_d(acc_d), .acc_o(acc_o), .res(res), .wr(wr)
    );

    for (genvar gi = 0; gi < NIN; gi++) begin : g_in
        logic [DW-1:0] q;
        // Operand register gi: loaded from the low word of the load port
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (ld_en && ld_tgt == TGW'(gi))
                q <= ld_data[DW-1:0];
        end
        assign in_q[gi] = q;
    end

    for (genvar ga = 0; ga < 2; ga++) begin : g_acc
        logic [AW-1:0] q;
        // Accumulator ga: load first, then operation result, else hold
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (ld_en && ld_tgt == TGW'(NIN + ga))
                q <= ld_acc_val;
            else if (op_valid && wr && acc_dst == 1'(ga))
                q <= res;
        end
        assign acc_q[ga] = q;
    end

    assign rd_full = acc_q[rd_sel];

    fmac_limiter #(.DW(DW), .EW(EW)) u_lim (
        .acc(rd_full), .wide(rd_wide), .data(rd_data), .ovf(rd_ovf)
    );

    // Sticky limit flag: a limited read sets it, a clear drops it, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim_flag <= 1'b0;
        else if (rd_en && rd_ovf)
            lim_flag <= 1'b1;
        else if (lim_clr)
            lim_flag <= 1'b0;
    end
endmodule

// File: rtl/fmac_unit_chk.sv
// Checker for fmac_unit: temporal properties over ports and accumulator
// state. Attached with the bind at the end of this file.
module fmac_unit_chk
    import fmac_pkg::*;
#(
    parameter int DW  = 24,
    parameter int EW  = 8,
    parameter int NIN = 4,
    localparam int AW  = 2*DW + EW,
    localparam int RW  = 2*DW,
    localparam int TGW = $clog2(NIN + 2)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           op_valid,
    input logic [OPW-1:0] op_code,
    input logic           acc_dst,
    input logic           ld_en,
    input logic [TGW-1:0] ld_tgt,
    input logic           rd_en,
    input logic           rd_wide,
    input logic           lim_clr,
    input logic [RW-1:0]  rd_data,
    input logic [AW-1:0]  rd_full,
    input logic           lim_flag,
    input logic [AW-1:0]  acc0,
    input logic [AW-1:0]  acc1
);
    localparam logic [AW-1:0] KEEP = {{EW{1'b1}}, {DW{1'b0}}, {DW{1'b1}}};
    localparam logic [RW-1:0] SAT_P = {{DW{1'b0}}, 1'b0, {DW-1{1'b1}}};
    localparam logic [RW-1:0] SAT_N = {{DW{1'b0}}, 1'b1, {DW-1{1'b0}}};

    logic          ovf_seen;
    logic          ld_acc;
    logic [AW-1:0] dsel;
    logic [AW-1:0] dsel_by_prev;
    logic          dst_q;
    op_e           op;

    // Decode port activity independently of the design
    always_comb begin
        op           = op_e'(op_code);
        ovf_seen     = rd_full[AW-1:RW] != {EW{rd_full[RW-1]}};
        ld_acc       = ld_en && (ld_tgt == TGW'(NIN) || ld_tgt == TGW'(NIN + 1));
        dsel         = acc_dst ? acc1 : acc0;
        dsel_by_prev = dst_q ? acc1 : acc0;
    end

    // Remember the previous destination select
    always_ff @(posedge clk) dst_q <= acc_dst;

    assert_sat_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_seen && !rd_wide) |-> rd_data == (rd_full[AW-1] ? SAT_N : SAT_P));

    assert_pass_wide_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_seen && rd_wide) |-> rd_data == rd_full[RW-1:0]);

    assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ovf_seen) |=> lim_flag);

    assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_flag && !lim_clr) |=> lim_flag);

    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_clr && !(rd_en && ovf_seen)) |=> !lim_flag);

    assert_logic_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_logic_op(op) && !ld_acc) |=> ((dsel_by_prev & KEEP) == ($past(dsel) & KEEP)));

    assert_round_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_ROUND && !ld_acc) |=> dsel_by_prev[DW-1:0] == '0);

    assert_nop_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_NOP && !ld_acc) |=> ($stable(acc0) && $stable(acc1)));

    assert_partner_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_dst && !ld_acc) |=> $stable(acc1));
endmodule

bind fmac_unit fmac_unit_chk #(.DW(DW), .EW(EW), .NIN(NIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_dst(acc_dst), .ld_en(ld_en), .ld_tgt(ld_tgt), .rd_en(rd_en),
    .rd_wide(rd_wide), .lim_clr(lim_clr), .rd_data(rd_data),
    .rd_full(rd_full), .lim_flag(lim_flag),
    .acc0(acc_q[0]), .acc1(acc_q[1])
);

// File: tb/tb_fmac_unit.sv
`timescale 1ns/1ps
module tb_fmac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [1:0]  src_a = '0;
    logic [1:0]  src_b = '0;
    logic        acc_dst = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_tgt = '0;
    logic        ld_wide = 1'b0;
    logic [47:0] ld_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic        rd_wide = 1'b0;
    logic        lim_clr = 1'b0;
    logic [47:0] rd_data;
    logic [55:0] rd_full;
    logic        lim_flag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    fmac_unit dut (.*);

    typedef struct packed {
        logic [3:0]  rq;
        logic [3:0]  op;
        logic [23:0] a;
        logic [23:0] b;
        logic [47:0] ia;
        logic [47:0] ib;
        logic [55:0] ex;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  4'd1,  24'h400000, 24'h400000, 48'h0,              48'h0,              56'h00_200000_000000}, // R3
        '{4'd3,  4'd1,  24'h800000, 24'h800000, 48'h0,              48'h0,              56'h00_800000_000000}, // R3
        '{4'd3,  4'd1,  24'h400000, 24'hC00000, 48'h0,              48'h0,              56'hFF_E00000_000000}, // R3
        '{4'd4,  4'd3,  24'h400000, 24'h400000, 48'h200000_000000,  48'h0,              56'h00_400000_000000}, // R4
        '{4'd4,  4'd4,  24'h400000, 24'h400000, 48'h200000_000000,  48'h0,              56'h00_000000_000000}, // R4
        '{4'd4,  4'd4,  24'h400000, 24'h400000, 48'h0,              48'h0,              56'hFF_E00000_000000}, // R4
        '{4'd5,  4'd2,  24'h400000, 24'h000003, 48'h0,              48'h0,              56'h00_000002_000000}, // R5
        '{4'd5,  4'd5,  24'h000001, 24'h000001, 48'h000002_7FFFFE,  48'h0,              56'h00_000002_000000}, // R5
        '{4'd5,  4'd5,  24'h000001, 24'h000001, 48'h000001_7FFFFE,  48'h0,              56'h00_000002_000000}, // R5
        '{4'd5,  4'd6,  24'h000001, 24'h000001, 48'h000005_900002,  48'h0,              56'h00_000006_000000}, // R5
        '{4'd5,  4'd10, 24'h0,      24'h0,      48'h000003_800000,  48'h0,              56'h00_000004_000000}, // R5
        '{4'd5,  4'd10, 24'h0,      24'h0,      48'h000004_800000,  48'h0,              56'h00_000004_000000}, // R5
        '{4'd5,  4'd10, 24'h0,      24'h0,      48'h000004_7FFFFF,  48'h0,              56'h00_000004_000000}, // R5
        '{4'd5,  4'd10, 24'h0,      24'h0,      48'hFFFFFF_800000,  48'h0,              56'h00_000000_000000}, // R5
        '{4'd6,  4'd7,  24'h0,      24'h0,      48'h400000_000000,  48'h400000_000000,  56'h00_800000_000000}, // R6
        '{4'd6,  4'd8,  24'h0,      24'h0,      48'h100000_000001,  48'h200000_000002,  56'hFF_EFFFFF_FFFFFF}, // R6
        '{4'd6,  4'd9,  24'h800000, 24'h0,      48'h000000_000005,  48'h0,              56'hFF_800000_000005}, // R6
        '{4'd7,  4'd11, 24'h0,      24'h0,      48'h400000_000001,  48'h0,              56'h00_800000_000002}, // R7
        '{4'd7,  4'd12, 24'h0,      24'h0,      48'h800000_000002,  48'h0,              56'hFF_C00000_000001}, // R7
        '{4'd8,  4'd13, 24'h0FF00F, 24'h0,      48'hF0F0F0_111111,  48'h0,              56'hFF_00F000_111111}, // R8
        '{4'd8,  4'd14, 24'h800001, 24'h0,      48'h123456_654321,  48'h0,              56'h00_923457_654321}, // R8
        '{4'd8,  4'd15, 24'hFFFFFF, 24'h0,      48'h00FF00_000000,  48'h0,              56'h00_FF00FF_000000}, // R8
        '{4'd9,  4'd0,  24'h0,      24'h0,      48'h111111_222222,  48'h0,              56'h00_111111_222222}  // R9
    };

    task automatic chk(input int rq, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] t, input logic w, input logic [47:0] d);
        ld_en = 1'b1; ld_tgt = t; ld_wide = w; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic issue(input logic [3:0] op, input logic [1:0] sa, input logic [1:0] sb, input logic dst);
        op_valid = 1'b1; op_code = op; src_a = sa; src_b = sb; acc_dst = dst;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic peek(input logic sel, input logic w);
        rd_sel = sel; rd_wide = w;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of accumulators, flag and operand registers
        peek(1'b0, 1'b1); chk(1, 64'(rd_full), 64'h0);
        peek(1'b1, 1'b1); chk(1, 64'(rd_full), 64'h0);
        chk(1, 64'(lim_flag), 64'h0);
        load(3'd4, 1'b1, 48'h123456_000000);
        issue(4'd1, 2'd1, 2'd3, 1'b0);
        peek(1'b0, 1'b1); chk(1, 64'(rd_full), 64'h0);

        // Vector table: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            load(3'd0, 1'b0, {24'h0, VECS[i].a});
            load(3'd2, 1'b0, {24'h0, VECS[i].b});
            load(3'd4, 1'b1, VECS[i].ia);
            load(3'd5, 1'b1, VECS[i].ib);
            issue(VECS[i].op, 2'd0, 2'd2, 1'b0);
            peek(1'b0, 1'b1);
            chk(int'(VECS[i].rq), 64'(rd_full), 64'(VECS[i].ex));
        end

        // R2: narrow and wide accumulator loads
        load(3'd4, 1'b0, 48'h000000_800000);
        peek(1'b0, 1'b1); chk(2, 64'(rd_full), 64'hFF_800000_000000);
        load(3'd5, 1'b1, 48'h7FFFFF_000001);
        peek(1'b1, 1'b1); chk(2, 64'(rd_full), 64'h00_7FFFFF_000001);

        // R9: operation into accumulator 1 leaves accumulator 0 alone
        load(3'd4, 1'b1, 48'h0A0A0A_050505);
        load(3'd0, 1'b0, 48'h400000);
        load(3'd2, 1'b0, 48'h400000);
        issue(4'd1, 2'd0, 2'd2, 1'b1);
        peek(1'b1, 1'b1); chk(9, 64'(rd_full), 64'h00_200000_000000);
        peek(1'b0, 1'b1); chk(9, 64'(rd_full), 64'h00_0A0A0A_050505);

        // R10: no-overflow reads pass through
        load(3'd4, 1'b1, 48'h123456_789ABC);
        peek(1'b0, 1'b0); chk(10, 64'(rd_data), 64'h123456);
        peek(1'b0, 1'b1); chk(10, 64'(rd_data), 64'h123456_789ABC);

        // R10 R11: positive overflow (+1.0) limited and flag set
        load(3'd0, 1'b0, 48'h800000);
        load(3'd2, 1'b0, 48'h800000);
        issue(4'd1, 2'd0, 2'd2, 1'b0);
        rd_en = 1'b1; peek(1'b0, 1'b0);
        chk(10, 64'(rd_data), 64'h7FFFFF);
        @(negedge clk); rd_en = 1'b0;
        chk(11, 64'(lim_flag), 64'h1);
        peek(1'b0, 1'b1); chk(10, 64'(rd_data), 64'h7FFFFF_FFFFFF);

        // R11: flag sticky across a clean read, then cleared
        load(3'd5, 1'b1, 48'h000001_000000);
        rd_en = 1'b1; peek(1'b1, 1'b0);
        @(negedge clk); rd_en = 1'b0;
        chk(11, 64'(lim_flag), 64'h1);
        lim_clr = 1'b1; @(negedge clk); lim_clr = 1'b0;
        chk(11, 64'(lim_flag), 64'h0);

        // R10: negative overflow limited in both widths
        load(3'd4, 1'b1, 48'h800000_000000);
        issue(4'd11, 2'd0, 2'd0, 1'b0);
        peek(1'b0, 1'b1); chk(7, 64'(rd_full), 64'hFF_000000_000000);
        peek(1'b0, 1'b0); chk(10, 64'(rd_data), 64'h800000);
        peek(1'b0, 1'b1); chk(10, 64'(rd_data), 64'h800000_000000);

        // R11: set and clear in the same cycle, set wins
        rd_en = 1'b1; lim_clr = 1'b1; peek(1'b0, 1'b0);
        @(negedge clk); rd_en = 1'b0; lim_clr = 1'b0;
        chk(11, 64'(lim_flag), 64'h1);

        // R12: operand reload in the same cycle as a multiply reading it
        load(3'd0, 1'b0, 48'h400000);
        load(3'd2, 1'b0, 48'h400000);
        ld_en = 1'b1; ld_tgt = 3'd0; ld_wide = 1'b0; ld_data = 48'h200000;
        issue(4'd1, 2'd0, 2'd2, 1'b0);
        ld_en = 1'b0;
        peek(1'b0, 1'b1); chk(12, 64'(rd_full), 64'h00_200000_000000);
        issue(4'd1, 2'd0, 2'd2, 1'b0);
        peek(1'b0, 1'b1); chk(12, 64'(rd_full), 64'h00_100000_000000);

        // R12: accumulator load beats an operation on the same accumulator
        ld_en = 1'b1; ld_tgt = 3'd4; ld_wide = 1'b1; ld_data = 48'h000000_000007;
        issue(4'd1, 2'd0, 2'd2, 1'b0);
        ld_en = 1'b0;
        peek(1'b0, 1'b1); chk(12, 64'(rd_full), 64'h00_000000_000007);

        finish_run();
    end
endmodule